// File: doc/BRIEF.md
# Multi-Modulus Three-Times Multiple Generator

This block produces the residue of three times an operand, 3X, for one of three related moduli: 2^N-1, 2^N and 2^N+1. A two-bit mode input picks the modulus, and the same carry network serves all three. It is meant to feed the hard multiple (the ±3X selection) of a radix-8 Booth modular multiplier. The doubled operand is not built by a separate adder input. It is wired from X itself as a rotate, a shift, or a rotate with an inverted wrapped bit. Pre-processing then merges each bit with its lower neighbour, which saves one prefix level.

For the 2^N+1 modulus, operands and results use diminished-1 coding: a stored code C stands for the value C+1. For 2^N-1 the all-ones code is a second encoding of zero. The adder is combinational. The result is captured in an output register with a synchronous active-high reset, so it appears one clock after the inputs.

Top module: `triple_multiple_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `h_out` becomes all zeros after that edge.
- R2: With `rst` low, `h_out` after a rising edge depends only on `x_in` and `mode_in` sampled at that edge. A change of the inputs between edges does not move `h_out`.
- R3: Mode code 2'b01 selects modulus 2^N: `h_out` equals (3·X) mod 2^N.
- R4: Mode code 2'b10 selects modulus 2^N-1: `h_out` is congruent to 3·X modulo 2^N-1, where the all-ones code counts as zero. An input whose sum X+2X fills all N bits without a carry returns the all-zeros code, not all ones.
- R5: Mode code 2'b00 selects modulus 2^N+1 with diminished-1 coding: `h_out` + 1 equals 3·(X+1) mod (2^N+1). The block is not required to handle a true product of zero, which has no diminished-1 code.
- R6: Mode code 2'b11 behaves exactly like 2'b01.
- R7: While `x_in` and `mode_in` hold steady and `rst` stays low, `h_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x_in | input | N | Operand X (diminished-1 code in mode 2'b00) |
| mode_in | input | 2 | Modulus select: 00 → 2^N+1, 01 → 2^N, 10 → 2^N-1, 11 → as 01 |
| h_out | output | N | Registered residue of 3·X for the selected modulus |

## Verification
The bench builds the block with N = 8. At that width all 256 operands can be swept in each of the three moduli, so every carry pattern through the two prefix levels is reached, including the wrap-around cases in bit 0 and the all-propagate sum. Because 257 is prime, no operand in the 2^N+1 mode maps to the product zero, so the whole diminished-1 sweep is valid. A short table of hand-worked vectors covers the reserved mode code and the returned zero in the 2^N-1 mode. Directed steps then check reset, the one-cycle capture, and the output holding steady.

// File: rtl/tmg_pkg.sv
package tmg_pkg;
  typedef enum logic [1:0] {
    MOD_PLUS1  = 2'b00,
    MOD_POW2   = 2'b01,
    MOD_MINUS1 = 2'b10,
    MOD_RSVD   = 2'b11
  } tmg_mode_e;
endpackage

// File: rtl/tmg_pre.sv
// Pre-processing: forms the doubled operand by wiring, the per-bit XOR term,
// and two-bit group generate/propagate pairs that exploit D[i] = X[i-1].
module tmg_pre
  import tmg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  tmg_mode_e    mode,
  output logic [N-1:0] gg,
  output logic [N-1:0] pp,
  output logic [N-1:0] tt
);
  logic wrap;
  logic [N-1:0] dbl;

  always_comb begin
    case (mode)
      MOD_MINUS1: wrap = x[N-1];
      MOD_PLUS1:  wrap = ~x[N-1];
      default:    wrap = 1'b0;
    endcase
  end

  assign dbl = {x[N-2:0], wrap};
  assign tt  = x ^ dbl;

  // bit 0 alone: addends x[0] and the wrapped bit
  assign gg[0] = x[0] & wrap;
  assign pp[0] = x[0] | wrap;

  // bits i and i-1 together; lower doubled bit is wrap for i==1, else x[i-2]
  for (genvar i = 1; i < N; i++) begin : g_pair
    logic lowd;
    if (i == 1) begin : g_first
      assign lowd = wrap;
    end else begin : g_rest
      assign lowd = x[i-2];
    end
    assign gg[i] = x[i-1] & (x[i] | lowd);
    assign pp[i] = (x[i] | x[i-1]) & (x[i-1] | lowd);
  end
endmodule

// File: rtl/tmg_prefix.sv
// Prefix carry network on pre-merged pairs: ceil(log2 N)-1 levels.
module tmg_prefix #(
  parameter int N = 8
) (
  input  logic [N-1:0] gin,
  input  logic [N-1:0] pin,
  output logic [N-1:0] gout,
  output logic [N-1:0] pout
);
  localparam int LVLS = $clog2(N) - 1;

  logic [LVLS:0][N-1:0] gs;
  logic [LVLS:0][N-1:0] ps;

  assign gs[0] = gin;
  assign ps[0] = pin;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int DIST = 2 << l;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= DIST) begin : g_op
        assign gs[l+1][i] = gs[l][i] | (ps[l][i] & gs[l][i-DIST]);
        assign ps[l+1][i] = ps[l][i] & ps[l][i-DIST];
      end else begin : g_pass
        assign gs[l+1][i] = gs[l][i];
        assign ps[l+1][i] = ps[l][i];
      end
    end
  end

  assign gout = gs[LVLS];
  assign pout = ps[LVLS];
endmodule

// File: rtl/tmg_post.sv
// Post-processing: mode-dependent carry-in, late carry injection, sum XOR.
module tmg_post
  import tmg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] tt,
  input  logic [N-1:0] gpre,
  input  logic [N-1:0] ppre,
  input  tmg_mode_e    mode,
  output logic [N-1:0] sum
);
  logic cin;
  logic [N-1:0] carry;

  always_comb begin
    case (mode)
      // end-around carry; all-propagate also wraps so the result reads zero
      MOD_MINUS1: cin = gpre[N-1] | ppre[N-1];
      // complemented end-around carry
      MOD_PLUS1:  cin = ~gpre[N-1];
      default:    cin = 1'b0;
    endcase
  end

  assign carry[0] = cin;
  for (genvar i = 1; i < N; i++) begin : g_car
    assign carry[i] = gpre[i-1] | (ppre[i-1] & cin);
  end

  assign sum = tt ^ carry;
endmodule

// File: rtl/triple_multiple_gen.sv
module triple_multiple_gen
  import tmg_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] x_in,
  input  logic [1:0]   mode_in,
  output logic [N-1:0] h_out
);
  tmg_mode_e    mode;
  logic [N-1:0] g_pre, p_pre, t_bits;
  logic [N-1:0] g_tree, p_tree;
  logic [N-1:0] h_next;

  assign mode = tmg_mode_e'(mode_in);

  tmg_pre #(.N(N)) u_pre (
    .x(x_in), .mode(mode), .gg(g_pre), .pp(p_pre), .tt(t_bits)
  );

  tmg_prefix #(.N(N)) u_tree (
    .gin(g_pre), .pin(p_pre), .gout(g_tree), .pout(p_tree)
  );

  tmg_post #(.N(N)) u_post (
    .tt(t_bits), .gpre(g_tree), .ppre(p_tree), .mode(mode), .sum(h_next)
  );

  always_ff @(posedge clk) begin
    if (rst) h_out <= '0;
    else     h_out <= h_next;
  end
endmodule

// File: rtl/triple_multiple_chk.sv
module triple_multiple_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] x_in,
  input logic [1:0]   mode_in,
  input logic [N-1:0] h_out
);
  localparam int W = N + 3;
  localparam logic [W-1:0] ONE_W = W'(1);
  localparam logic [W-1:0] M_LO  = (ONE_W << N) - ONE_W;
  localparam logic [W-1:0] M_HI  = (ONE_W << N) + ONE_W;

  logic [N-1:0] x_d, x_dd;
  logic [1:0]   m_d, m_dd;
  logic         v1, v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= 1'b1;
      v2 <= v1;
    end
    x_d  <= x_in;
    x_dd <= x_d;
    m_d  <= mode_in;
    m_dd <= m_d;
  end

  logic [W-1:0] triple, exp_lo, got_lo, exp_hi, got_hi;
  always_comb begin
    triple = W'(x_d) * W'(3);
    exp_lo = triple % M_LO;
    got_lo = W'(h_out) % M_LO;
    exp_hi = ((W'(x_d) + ONE_W) * W'(3)) % M_HI;
    got_hi = W'(h_out) + ONE_W;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (h_out == '0));

  assert_pow2_residue_R3: assert property (@(posedge clk) disable iff (rst)
    (v1 && m_d == 2'b01) |-> (h_out == triple[N-1:0]));

  assert_minus1_residue_R4: assert property (@(posedge clk) disable iff (rst)
    (v1 && m_d == 2'b10) |-> (got_lo == exp_lo));

  assert_plus1_residue_R5: assert property (@(posedge clk) disable iff (rst)
    (v1 && m_d == 2'b00) |-> (got_hi == exp_hi));

  assert_reserved_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (v1 && m_d == 2'b11) |-> (h_out == triple[N-1:0]));

  assert_steady_output_R7: assert property (@(posedge clk) disable iff (rst)
    (v2 && x_d == x_dd && m_d == m_dd) |-> $stable(h_out));
endmodule

bind triple_multiple_gen triple_multiple_chk #(.N(N)) u_chk (.*);

// File: tb/tb_triple_multiple_gen.sv
module tb_triple_multiple_gen;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] x_in = '0;
  logic [1:0]   mode_in = 2'b01;
  logic [N-1:0] h_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  triple_multiple_gen #(.N(N)) dut (
    .clk(clk), .rst(rst), .x_in(x_in), .mode_in(mode_in), .h_out(h_out)
  );

  always #5 clk = ~clk;

  // {mode, x, expected}
  localparam logic [17:0] TBL [11] = '{
    {2'b01, 8'h55, 8'hFF},
    {2'b01, 8'hAB, 8'h01},
    {2'b10, 8'h80, 8'h81},
    {2'b10, 8'h55, 8'h00},
    {2'b10, 8'hFF, 8'hFF},
    {2'b10, 8'h00, 8'h00},
    {2'b00, 8'hFF, 8'hFD},
    {2'b00, 8'h00, 8'h02},
    {2'b00, 8'h55, 8'h00},
    {2'b11, 8'h55, 8'hFF},
    {2'b11, 8'hAB, 8'h01}
  };

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R5";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [N-1:0] x);
    @(negedge clk);
    mode_in = m;
    x_in    = x;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] held;
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check(h_out == '0, "R1", h_out, '0);
    @(negedge clk);
    rst = 1'b0;

    // table of hand-worked vectors
    for (int k = 0; k < 11; k++) begin
      apply(TBL[k][17:16], TBL[k][15:8]);
      check(h_out == TBL[k][7:0], tag_of(TBL[k][17:16]), h_out, TBL[k][7:0]);
    end

    // exhaustive sweep of all operands in the three moduli
    for (int m = 0; m < 3; m++) begin
      for (int x = 0; x < 256; x++) begin
        int exp;
        bit ok;
        apply(2'(m), 8'(x));
        if (m == 1) begin
          exp = (3 * x) % 256;
          ok  = (int'(h_out) == exp);
        end else if (m == 2) begin
          exp = (3 * x) % 255;
          ok  = ((int'(h_out) % 255) == exp);
        end else begin
          exp = ((3 * (x + 1)) % 257) - 1;
          ok  = (int'(h_out) == exp);
        end
        check(ok, tag_of(2'(m)), h_out, 8'(exp));
      end
    end

    // R2: an input change between edges does not move the output
    apply(2'b01, 8'h02);
    held = h_out;
    @(negedge clk);
    x_in = 8'h40;
    #2;
    check(h_out == held, "R2", h_out, held);
    @(posedge clk);
    #1;
    check(h_out == 8'hC0, "R2", h_out, 8'hC0);

    // R7: steady inputs keep the output steady
    apply(2'b00, 8'h10);
    held = h_out;
    @(posedge clk);
    #1;
    check(h_out == held, "R7", h_out, held);
    check(h_out == 8'h32, "R5", h_out, 8'h32);

    // R1: reset in the middle of operation with a nonzero result pending
    @(negedge clk);
    rst     = 1'b1;
    x_in    = 8'h77;
    mode_in = 2'b01;
    @(posedge clk);
    #1;
    check(h_out == '0, "R1", h_out, '0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(h_out == 8'h65, "R3", h_out, 8'h65);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule